// File: doc/BRIEF.md
# Four-Cell Passive Balancing Controller

This block decides, once per measurement strobe, which of the four series cells of a battery pack should have its bleed resistor switched in. It reads digitized cell voltages in millivolts, one signed pack current sample in milliamps and one temperature sample per cell in degrees. From the sign of the current it derives a charging, discharging or idle state. While charging it bleeds the cells that run ahead of the weakest cell. A latched over-temperature cutoff stops all bleeding.

The full and empty voltage limits and the temperature limit arrive as register values from a host-side interface outside the block. The host can also force one chosen cell's bleed path on for a set number of clock cycles, after which automatic control resumes. The outputs give registered indications for charging, discharging, bleeding activity, a fully-charged pack and an under-voltage pack.

Timing: mode, done, under-voltage, over-temperature and the internal automatic decision update on the clock edge that samples `smp_vld`. `bleed_en` and `st_active` update on the edge after that.

Top module: `cell_balance_ctrl`

## Requirements
- R1: After reset every output is 0 and the mode is idle.
- R2: Mode follows pack current, where positive means charging. Idle enters charging at current >= 100 mA and discharging at current <= -100 mA. Charging holds while current >= 50 mA and discharging holds while current <= -50 mA. When a mode is left, the next mode is charging if current >= 100 mA, discharging if current <= -100 mA, and idle otherwise. `st_charge` and `st_discharge` show the mode.
- R3: In charging mode, with no over-temperature, the bleed bit of a cell that is not bleeding (`bleed_en[i]` for cell i, where cell i is `cell_mv[i*13 +: 13]`) turns on when its voltage is at least 50 mV above the lowest cell.
- R4: A bleeding cell stays on while its excess over the lowest cell is at least 25 mV, and turns off below that.
- R5: In idle or discharging mode no cell bleeds automatically.
- R6: Over-temperature sets when any cell temperature is >= `lim_temp`. It clears only when every temperature is <= `lim_temp` - 5. While it is set, every bleed bit is 0, including a manual one.
- R7: A one-cycle `man_go` loads `man_sel` and `man_cycles` (N). The selected cell bleeds for exactly N cycles, starting on the edge after `man_go`. The other cells stay under automatic control.
- R8: `done` is 1 when every cell is >= `lim_full` and no automatic bleed decision is active.
- R9: `under_volt` is 1 in discharging mode when any cell is <= `lim_empty`, and 0 otherwise.
- R10: `st_active` is 1 exactly when any bit of `bleed_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| smp_vld | input | 1 | one-cycle strobe, new samples valid |
| cell_mv | input | 52 | four cell voltages in mV, cell 0 in the low bits |
| pack_ma | input | 16 | signed pack current in mA, positive = charging |
| cell_deg | input | 32 | four cell temperatures in degrees, cell 0 in the low bits |
| lim_full | input | 13 | full-cell voltage limit in mV |
| lim_empty | input | 13 | empty-cell voltage limit in mV |
| lim_temp | input | 8 | over-temperature limit in degrees |
| man_go | input | 1 | start a manual timed bleed |
| man_sel | input | 2 | cell index for manual bleed |
| man_cycles | input | 16 | manual bleed length in clock cycles |
| bleed_en | output | 4 | per-cell bleed enable |
| st_charge | output | 1 | charging mode |
| st_discharge | output | 1 | discharging mode |
| st_active | output | 1 | any cell bleeding |
| done | output | 1 | pack full |
| under_volt | output | 1 | under-voltage while discharging |
| over_temp | output | 1 | latched over-temperature |

## Verification
The bleed decision is swept over every excess from 0 to 80 mV, with each of the four cells in turn as the high cell. Sweeps start from a cleared state, which exposes the 50 mV turn-on edge, and from a bleeding state walked downward, which exposes the 25 mV hold edge and so tells the turn-on threshold apart from the hold threshold. A current sequence walks through both deadbands to separate the enter thresholds from the hold thresholds. Temperature steps at the limit, one above the release point and at the release point show the latch behaviour. Manual bleeds are timed cycle by cycle, both with and without the thermal cutoff.

// File: rtl/cbal_pkg.sv
package cbal_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CHG  = 2'd1,
    MODE_DIS  = 2'd2
  } mode_e;
endpackage

// File: rtl/cbal_mode.sv
module cbal_mode
  import cbal_pkg::*;
#(
  parameter int IW     = 16,
  parameter int ON_MA  = 100,
  parameter int OFF_MA = 50
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [IW-1:0] cur,
  output mode_e                mode_n,
  output mode_e                mode_q
);
  logic signed [31:0] c;
  logic go_chg, go_dis;

  always_comb begin
    c      = 32'(cur);
    go_chg = (c >= ON_MA);
    go_dis = (c <= -ON_MA);
    case (mode_q)
      MODE_CHG: mode_n = (c >= OFF_MA) ? MODE_CHG : (go_dis ? MODE_DIS : MODE_IDLE);
      MODE_DIS: mode_n = (c <= -OFF_MA) ? MODE_DIS : (go_chg ? MODE_CHG : MODE_IDLE);
      default:  mode_n = go_chg ? MODE_CHG : (go_dis ? MODE_DIS : MODE_IDLE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      mode_q <= MODE_IDLE;
    else if (upd) mode_q <= mode_n;
  end
endmodule

// File: rtl/cbal_auto.sv
module cbal_auto #(
  parameter int N      = 4,
  parameter int VW     = 13,
  parameter int ON_MV  = 50,
  parameter int OFF_MV = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic          allow,
  input  logic [N*VW-1:0] volts,
  output logic [N-1:0]  auto_n,
  output logic [N-1:0]  auto_q
);
  logic [VW-1:0] vmin;

  always_comb begin
    vmin = volts[VW-1:0];
    for (int i = 1; i < N; i++)
      if (volts[i*VW +: VW] < vmin) vmin = volts[i*VW +: VW];
  end

  for (genvar g = 0; g < N; g++) begin : g_cell
    logic [VW-1:0] excess;
    logic [31:0]   thr;
    always_comb begin
      excess    = volts[g*VW +: VW] - vmin;
      thr       = auto_q[g] ? 32'(OFF_MV) : 32'(ON_MV);
      auto_n[g] = allow && (32'(excess) >= thr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      auto_q <= '0;
    else if (upd) auto_q <= auto_n;
  end
endmodule

// File: rtl/cbal_thermal.sv
module cbal_thermal #(
  parameter int N    = 4,
  parameter int TW   = 8,
  parameter int HYST = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [N*TW-1:0] temps,
  input  logic [TW-1:0] limit,
  output logic          ot_n,
  output logic          ot_q
);
  logic hot, cool;

  always_comb begin
    hot  = 1'b0;
    cool = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (temps[i*TW +: TW] >= limit) hot = 1'b1;
      if (32'(temps[i*TW +: TW]) + HYST > 32'(limit)) cool = 1'b0;
    end
    ot_n = ot_q ? !cool : hot;
  end

  always_ff @(posedge clk) begin
    if (rst)      ot_q <= 1'b0;
    else if (upd) ot_q <= ot_n;
  end
endmodule

// File: rtl/cell_balance_ctrl.sv
module cell_balance_ctrl
  import cbal_pkg::*;
#(
  parameter int NCELL = 4,
  parameter int VW    = 13,
  parameter int IW    = 16,
  parameter int TW    = 8,
  parameter int DW    = 16,
  localparam int CW   = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_vld,
  input  logic [NCELL*VW-1:0]   cell_mv,
  input  logic signed [IW-1:0]  pack_ma,
  input  logic [NCELL*TW-1:0]   cell_deg,
  input  logic [VW-1:0]         lim_full,
  input  logic [VW-1:0]         lim_empty,
  input  logic [TW-1:0]         lim_temp,
  input  logic                  man_go,
  input  logic [CW-1:0]         man_sel,
  input  logic [DW-1:0]         man_cycles,
  output logic [NCELL-1:0]      bleed_en,
  output logic                  st_charge,
  output logic                  st_discharge,
  output logic                  st_active,
  output logic                  done,
  output logic                  under_volt,
  output logic                  over_temp
);
  mode_e            mode_n, mode_q;
  logic             ot_n, ot_q;
  logic [NCELL-1:0] auto_n, auto_q;
  logic [DW-1:0]    man_cnt;
  logic [CW-1:0]    man_idx;
  logic [NCELL-1:0] man_mask, bleed_n;
  logic             all_full, any_low;

  cbal_mode #(.IW(IW)) u_mode (
    .clk(clk), .rst(rst), .upd(smp_vld), .cur(pack_ma),
    .mode_n(mode_n), .mode_q(mode_q)
  );

  cbal_thermal #(.N(NCELL), .TW(TW)) u_therm (
    .clk(clk), .rst(rst), .upd(smp_vld), .temps(cell_deg), .limit(lim_temp),
    .ot_n(ot_n), .ot_q(ot_q)
  );

  cbal_auto #(.N(NCELL), .VW(VW)) u_auto (
    .clk(clk), .rst(rst), .upd(smp_vld),
    .allow((mode_n == MODE_CHG) && !ot_n),
    .volts(cell_mv), .auto_n(auto_n), .auto_q(auto_q)
  );

  always_comb begin
    all_full = 1'b1;
    any_low  = 1'b0;
    for (int i = 0; i < NCELL; i++) begin
      if (cell_mv[i*VW +: VW] < lim_full)   all_full = 1'b0;
      if (cell_mv[i*VW +: VW] <= lim_empty) any_low  = 1'b1;
    end
    man_mask = '0;
    if (man_cnt != '0) man_mask[man_idx] = 1'b1;
    bleed_n = ot_q ? '0 : (auto_q | man_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      man_cnt <= '0;
      man_idx <= '0;
    end else if (man_go) begin
      man_cnt <= man_cycles;
      man_idx <= man_sel;
    end else if (man_cnt != '0) begin
      man_cnt <= man_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      under_volt <= 1'b0;
      bleed_en   <= '0;
      st_active  <= 1'b0;
    end else begin
      bleed_en  <= bleed_n;
      st_active <= |bleed_n;
      if (smp_vld) begin
        done       <= all_full && (auto_n == '0);
        under_volt <= (mode_n == MODE_DIS) && any_low;
      end
    end
  end

  assign st_charge    = (mode_q == MODE_CHG);
  assign st_discharge = (mode_q == MODE_DIS);
  assign over_temp    = ot_q;
endmodule

// File: rtl/cbal_chk.sv
module cbal_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] bleed_en,
  input logic [N-1:0] auto_q,
  input logic         st_charge,
  input logic         st_discharge,
  input logic         done,
  input logic         under_volt,
  input logic         over_temp
);
  // R6
  ot_blocks_bleed_chk: assert property (@(posedge clk) disable iff (rst)
    $past(over_temp) |-> (bleed_en == '0));
  // R5
  auto_only_charging_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_q != '0) |-> st_charge);
  // R2
  mode_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_charge && st_discharge));
  // R9
  uv_needs_discharge_chk: assert property (@(posedge clk) disable iff (rst)
    under_volt |-> st_discharge);
  // R8
  done_no_auto_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (auto_q == '0));
endmodule

bind cell_balance_ctrl cbal_chk #(.N(NCELL)) u_chk (
  .clk(clk), .rst(rst), .bleed_en(bleed_en), .auto_q(auto_q),
  .st_charge(st_charge), .st_discharge(st_discharge), .done(done),
  .under_volt(under_volt), .over_temp(over_temp)
);

// File: tb/tb_cell_balance_ctrl.sv
module tb_cell_balance_ctrl;
  logic clk = 0, rst = 1, smp_vld = 0, man_go = 0;
  logic [51:0] cell_mv = '0;
  logic signed [15:0] pack_ma = '0;
  logic [31:0] cell_deg = '0;
  logic [12:0] lim_full = 13'd3600, lim_empty = 13'd2800;
  logic [7:0]  lim_temp = 8'd60;
  logic [1:0]  man_sel = '0;
  logic [15:0] man_cycles = '0;
  logic [3:0]  bleed_en;
  logic st_charge, st_discharge, st_active, done, under_volt, over_temp;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cell_balance_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_cells(int a, int b, int c, int d);
    cell_mv = {13'(d), 13'(c), 13'(b), 13'(a)};
  endtask

  task automatic set_temps(int a, int b, int c, int d);
    cell_deg = {8'(d), 8'(c), 8'(b), 8'(a)};
  endtask

  // strobe one sample, return after the bleed output has updated
  task automatic sample();
    smp_vld = 1;
    @(negedge clk);
    smp_vld = 0;
    @(negedge clk);
  endtask

  task automatic clear_auto();
    set_cells(3300, 3300, 3300, 3300);
    sample();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_temps(25, 25, 25, 25);
    set_cells(3300, 3300, 3300, 3300);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bleed", bleed_en, 0);
    chk("R1 flags", {st_charge, st_discharge, st_active, done, under_volt, over_temp}, 0);
    rst = 0;
    @(negedge clk);

    // R2 mode walk through deadbands
    pack_ma = 200;  sample(); chk("R2 chg", {st_charge, st_discharge}, 2'b10);
    pack_ma = 60;   sample(); chk("R2 chg hold", {st_charge, st_discharge}, 2'b10);
    pack_ma = 40;   sample(); chk("R2 idle", {st_charge, st_discharge}, 2'b00);
    pack_ma = 80;   sample(); chk("R2 idle below on", {st_charge, st_discharge}, 2'b00);
    pack_ma = -80;  sample(); chk("R2 idle neg", {st_charge, st_discharge}, 2'b00);
    pack_ma = -120; sample(); chk("R2 dis", {st_charge, st_discharge}, 2'b01);
    pack_ma = -60;  sample(); chk("R2 dis hold", {st_charge, st_discharge}, 2'b01);
    pack_ma = 150;  sample(); chk("R2 dis to chg", {st_charge, st_discharge}, 2'b10);

    // R3 turn-on sweep, every cell as the high one
    for (int hi = 0; hi < 4; hi++)
      for (int d = 0; d <= 80; d++) begin
        clear_auto();
        cell_mv[hi*13 +: 13] = 13'(3300 + d);
        sample();
        chk("R3 on sweep", bleed_en, (d >= 50) ? (32'd1 << hi) : 0);
        chk("R10 active", st_active, (d >= 50) ? 1 : 0);
      end

    // R4 hold sweep downward from a bleeding state
    for (int hi = 0; hi < 4; hi++) begin
      clear_auto();
      for (int d = 80; d >= 0; d--) begin
        cell_mv = {4{13'd3300}};
        cell_mv[hi*13 +: 13] = 13'(3300 + d);
        sample();
        chk("R4 hold sweep", bleed_en, (d >= 25) ? (32'd1 << hi) : 0);
      end
    end

    // R3/R4 mixed cells
    clear_auto();
    set_cells(3300, 3360, 3350, 3320); sample();
    chk("R3 mixed", bleed_en, 4'b0110);
    set_cells(3300, 3330, 3324, 3340); sample();
    chk("R4 mixed", bleed_en, 4'b0010);

    // R5 no automatic bleed while discharging or idle
    set_cells(3300, 3400, 3300, 3300);
    pack_ma = -200; sample();
    chk("R5 dis", bleed_en, 0);
    pack_ma = 0; sample();
    chk("R5 idle", bleed_en, 0);

    // R9 under-voltage
    pack_ma = -200;
    set_cells(3000, 2800, 3000, 3000); sample();
    chk("R9 at limit", under_volt, 1);
    set_cells(3000, 2801, 3000, 3000); sample();
    chk("R9 above", under_volt, 0);
    pack_ma = 200;
    set_cells(3000, 2800, 3000, 3000); sample();
    chk("R9 charging", under_volt, 0);

    // R8 done
    clear_auto();
    set_cells(3600, 3620, 3640, 3630); sample();
    chk("R8 full", done, 1);
    set_cells(3599, 3620, 3640, 3630); sample();
    chk("R8 one low", done, 0);
    set_cells(3600, 3660, 3600, 3600); sample();
    chk("R8 bleeding", done, 0);

    // R6 over-temperature latch
    set_cells(3300, 3400, 3300, 3300);
    set_temps(25, 25, 60, 25); sample();
    chk("R6 set", over_temp, 1);
    chk("R6 blocks", bleed_en, 0);
    set_temps(25, 25, 56, 25); sample();
    chk("R6 held", over_temp, 1);
    chk("R6 held blocks", bleed_en, 0);
    set_temps(25, 25, 55, 25); sample();
    chk("R6 release", over_temp, 0);
    chk("R6 bleed back", bleed_en, 4'b0010);

    // R7 manual timed bleed in discharging mode
    pack_ma = -200; set_cells(3300, 3300, 3300, 3300); sample();
    man_sel = 2; man_cycles = 5; man_go = 1;
    @(negedge clk); man_go = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7 on", bleed_en, 4'b0100);
    end
    @(negedge clk);
    chk("R7 off", bleed_en, 0);

    // R7 manual bleed alongside automatic bleed on another cell
    pack_ma = 200; set_cells(3300, 3400, 3300, 3300); sample();
    man_sel = 0; man_cycles = 3; man_go = 1;
    @(negedge clk); man_go = 0;
    @(negedge clk);
    chk("R7 with auto", bleed_en, 4'b0011);
    repeat (3) @(negedge clk);
    chk("R7 auto stays", bleed_en, 4'b0010);

    // R6 manual blocked under over-temperature
    set_temps(70, 25, 25, 25); sample();
    man_sel = 1; man_cycles = 3; man_go = 1;
    @(negedge clk); man_go = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 manual blocked", bleed_en, 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule